// File: doc/BRIEF.md
# Cascaded Long-Delay Timer

This block builds a very long delay out of a fast system clock without any processor activity while the delay runs. A free-running 10-bit prescaler supplies tick taps to a 16-bit compare timer. Each time the timer has counted the programmed number of ticks it flips a toggle output and restarts from zero. The toggle output is fed back through a synchronizer into an 8-bit event counter that counts its rising edges, starting from a programmable preload. When the event counter wraps, a sticky flag is raised and, if enabled, an interrupt.

Software picks a tick source, writes a compare value and a preload, pulses `load_i`, and then holds `run_i` high. The flag rises after `prescale * 2 * compare * (256 - preload) + 3` running clock cycles. Dropping `run_i` freezes the whole chain, and raising it again resumes the count from where it stopped.

Top module: `long_delay_timer`

## Requirements
- R1: After reset `tgl_o` is 1, `evt_cnt_o` is 0, and `flag_o` and `irq_o` are 0.
- R2: `clk_sel_i` selects the tick source. 0 and 7 select none, 1 selects every clock, 2 selects 1 in 8, 3 selects 1 in 64, 4 selects 1 in 256, 5 selects 1 in 1024, and 6 selects each synchronized rising edge of `ext_clk_i`. With source 1 to 5, `flag_o` is first seen high after exactly prescale*2*C*(256-P)+3 clock edges with `run_i` high, counted from the end of a load.
- R3: The compare timer counts ticks from 0. On the tick where it has counted C ticks (C = `cmp_val_i`; C = 0 means 65536), it inverts `tgl_o` and restarts at 0.
- R4: The event counter increments once for each rising edge of `tgl_o`, three clocks after the edge. A `load_i` pulse sets it to `preload_i`, clears the prescaler and the compare count, and sets `tgl_o` to 1 without producing an event.
- R5: When the event counter steps from 0xFF to 0x00, `flag_o` is set. The flag then stays set until a cycle with `flag_clr_i` high and no new overflow. If a clear and an overflow fall in the same cycle, the flag stays set.
- R6: `irq_o` is high exactly when `flag_o` is high and `irq_en_i` is high.
- R7: While `run_i` is low, the prescaler, compare timer, synchronizer and event counter hold their state, and `tgl_o` keeps its level. Resuming continues the delay without loss, so the total number of running cycles stays as given in R2.
- R8: With source 6, one rising edge of `ext_clk_i` (held at least one clock per level) advances the compare timer by one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 runs the chain, 0 freezes it |
| clk_sel_i | input | 3 | Tick source select |
| ext_clk_i | input | 1 | External tick source, asynchronous |
| cmp_val_i | input | 16 | Compare value C |
| preload_i | input | 8 | Event counter start value P |
| load_i | input | 1 | Load strobe |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| tgl_o | output | 1 | Compare toggle output |
| evt_cnt_o | output | 8 | Event counter value |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The delay is measured end to end for every prescale tap and for compare values of 0, 1, 2 and 3, with preloads from 0 to 255. These cases show whether the tap widths are right, whether the compare counter is off by one, whether the toggle really divides by two, and whether the full-range compare wraps correctly. A run that is paused while an edge is still in the synchronizer shows whether the freeze loses or duplicates events. Single external pulses show that one edge gives one tick. A clear that lands in the same cycle as an overflow shows which of the two wins.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [2:0] {
    CS_NONE    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5,
    CS_EXT     = 3'd6,
    CS_OFF     = 3'd7
  } clk_sel_e;

  localparam int NUM_TAPS = 4;
endpackage

// File: rtl/ld_prescaler.sv
module ld_prescaler
  import ld_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  localparam int TAP_BITS [NUM_TAPS] = '{3, 6, 8, 10};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_o[g] = run_i && (&cnt_q[TAP_BITS[g]-1:0]);
  end
endmodule

// File: rtl/ld_edge_sync.sv
module ld_edge_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic preset_i,
  input  logic d_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= {3{INIT}};
    else if (preset_i) sh_q <= {3{INIT}};
    else if (en_i)     sh_q <= {sh_q[1:0], d_i};
  end

  assign rise_o = en_i && !preset_i && sh_q[1] && !sh_q[2];
endmodule

// File: rtl/ld_cmp_timer.sv
module ld_cmp_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] cmp_i,
  output logic         tgl_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;
  logic         match;

  // cmp 0 wraps to all-ones: full 2^W period
  assign last  = cmp_i - 1'b1;
  assign match = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgl_o <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      tgl_o <= 1'b1;
    end else if (tick_i) begin
      if (match) begin
        cnt_q <= '0;
        tgl_o <= ~tgl_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ld_event_counter.sv
module ld_event_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] preload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= preload_i;
    else if (step_i)  cnt_o <= cnt_o + 1'b1;
  end

  assign ovf_o = step_i && !load_i && (&cnt_o);
endmodule

// File: rtl/long_delay_timer.sv
module long_delay_timer
  import ld_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int CMP_W   = 16,
  parameter int EVT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [2:0]       clk_sel_i,
  input  logic             ext_clk_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  input  logic [EVT_W-1:0] preload_i,
  input  logic             load_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic             tgl_o,
  output logic [EVT_W-1:0] evt_cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [NUM_TAPS-1:0] tap;
  logic                ext_rise;
  logic                tick;
  logic                evt_step;
  logic                evt_ovf;
  clk_sel_e            sel;

  assign sel = clk_sel_e'(clk_sel_i);

  ld_prescaler #(.W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .clr_i  (load_i),
    .tap_o  (tap)
  );

  ld_edge_sync #(.INIT(1'b0)) u_ext_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (1'b1),
    .preset_i (1'b0),
    .d_i      (ext_clk_i),
    .rise_o   (ext_rise)
  );

  always_comb begin
    case (sel)
      CS_DIV1:    tick = run_i;
      CS_DIV8:    tick = tap[0];
      CS_DIV64:   tick = tap[1];
      CS_DIV256:  tick = tap[2];
      CS_DIV1024: tick = tap[3];
      CS_EXT:     tick = run_i && ext_rise;
      default:    tick = 1'b0;
    endcase
  end

  ld_cmp_timer #(.W(CMP_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick && !load_i),
    .clr_i  (load_i),
    .cmp_i  (cmp_val_i),
    .tgl_o  (tgl_o)
  );

  // toggle resynchronized as event clock; frozen with the chain
  ld_edge_sync #(.INIT(1'b1)) u_evt_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (run_i),
    .preset_i (load_i),
    .d_i      (tgl_o),
    .rise_o   (evt_step)
  );

  ld_event_counter #(.W(EVT_W)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (evt_step),
    .load_i    (load_i),
    .preload_i (preload_i),
    .cnt_o     (evt_cnt_o),
    .ovf_o     (evt_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= evt_ovf || (flag_o && !flag_clr_i);
  end

  assign irq_o = flag_o && irq_en_i;
endmodule

// File: rtl/ld_checker.sv
module ld_checker #(
  parameter int EVT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             load_i,
  input logic             flag_clr_i,
  input logic             tgl_o,
  input logic [EVT_W-1:0] evt_cnt_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             ovf_i
);
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R5
  AST_OVF_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (flag_o && evt_cnt_o == '0)); // R5
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !ovf_i) |=> !flag_o); // R5
  AST_NO_IRQ_WITHOUT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o |-> !irq_o); // R6
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> ($stable(tgl_o) && $stable(evt_cnt_o))); // R7
  AST_EVT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (evt_cnt_o == $past(evt_cnt_o) ||
                 evt_cnt_o == EVT_W'($past(evt_cnt_o) + 1'b1))); // R4
endmodule

bind long_delay_timer ld_checker #(.EVT_W(EVT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .load_i     (load_i),
  .flag_clr_i (flag_clr_i),
  .tgl_o      (tgl_o),
  .evt_cnt_o  (evt_cnt_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .ovf_i      (evt_ovf)
);

// File: tb/sim_long_delay_timer.sv
`timescale 1ns/1ps
module sim_long_delay_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [2:0]  clk_sel_i = 3'd1;
  logic        ext_clk_i = 1'b0;
  logic [15:0] cmp_val_i = 16'd1;
  logic [7:0]  preload_i = 8'd0;
  logic        load_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic        tgl_o;
  logic [7:0]  evt_cnt_o;
  logic        flag_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  long_delay_timer u0 (.*);

  // {sel, cmp, preload}
  localparam logic [26:0] VEC [7] = '{
    {3'd1, 16'd3, 8'd250},
    {3'd2, 16'd2, 8'd253},
    {3'd3, 16'd1, 8'd254},
    {3'd4, 16'd2, 8'd255},
    {3'd5, 16'd1, 8'd255},
    {3'd1, 16'd1, 8'd0},
    {3'd1, 16'd0, 8'd255}
  };

  function automatic int presc_of(logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk_i) flag_clr_i = 1'b1;
    @(negedge clk_i) flag_clr_i = 1'b0;
  endtask

  task automatic do_load(logic [2:0] s, logic [15:0] c, logic [7:0] p);
    @(negedge clk_i);
    run_i = 1'b0; clk_sel_i = s; cmp_val_i = c; preload_i = p; load_i = 1'b1;
    @(negedge clk_i) load_i = 1'b0;
  endtask

  // counts running edges until flag_o seen; run_i left low
  task automatic run_count(int limit, inout int n);
    run_i = 1'b1;
    while (n < limit) begin
      @(posedge clk_i) n++;
      @(negedge clk_i);
      if (flag_o) break;
    end
    run_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int exp;
    repeat (3) @(negedge clk_i);
    chk(tgl_o == 1'b1, "R1 tgl", tgl_o, 1);
    chk(evt_cnt_o == 8'd0 && !flag_o && !irq_o, "R1 evt/flag/irq",
        {evt_cnt_o, flag_o, irq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4: delay per tick source, compare value and preload
    foreach (VEC[i]) begin
      logic [2:0] s; logic [15:0] c; logic [7:0] p; int ce;
      {s, c, p} = VEC[i];
      ce = (c == 16'd0) ? 65536 : int'(c);
      exp = presc_of(s) * 2 * ce * (256 - int'(p)) + 3;
      clear_flag();
      do_load(s, c, p);
      chk(evt_cnt_o == p, "R4 preload", evt_cnt_o, p);
      n = 0;
      run_count(exp + 50, n);
      chk(n == exp, "R2 R3 delay", n, exp);
      chk(evt_cnt_o == 8'd0 && flag_o, "R5 wrap sets flag", evt_cnt_o, 0);
    end

    // R6 masking and R5 stickiness
    irq_en_i = 1'b0;
    @(negedge clk_i);
    chk(!irq_o, "R6 masked", irq_o, 0);
    irq_en_i = 1'b1;
    @(negedge clk_i);
    chk(irq_o, "R6 enabled", irq_o, 1);
    repeat (20) @(negedge clk_i);
    chk(flag_o, "R5 sticky", flag_o, 1);
    clear_flag();
    chk(!flag_o && !irq_o, "R5 R6 clear", flag_o, 0);

    // R7 freeze mid-delay with an edge in flight
    do_load(3'd1, 16'd3, 8'd250);
    n = 0;
    run_count(20, n);
    begin
      logic t0; logic [7:0] e0;
      t0 = tgl_o; e0 = evt_cnt_o;
      repeat (30) @(negedge clk_i);
      chk(tgl_o == t0, "R7 tgl held", tgl_o, t0);
      chk(evt_cnt_o == e0, "R7 evt held", evt_cnt_o, e0);
    end
    run_count(200, n);
    chk(n == 39, "R7 resumed delay", n, 39);
    clear_flag();

    // R5 clear and overflow in the same cycle: flag wins
    do_load(3'd1, 16'd1, 8'd255);
    run_i = 1'b1;
    repeat (4) @(negedge clk_i);
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0; run_i = 1'b0;
    chk(flag_o, "R5 clear vs overflow", flag_o, 1);
    clear_flag();

    // R2 select 0: no ticks
    do_load(3'd0, 16'd1, 8'd255);
    run_i = 1'b1;
    repeat (100) @(negedge clk_i);
    run_i = 1'b0;
    chk(tgl_o && evt_cnt_o == 8'd255 && !flag_o, "R2 source none",
        {tgl_o, evt_cnt_o, flag_o}, {1'b1, 8'd255, 1'b0});

    // R8 external source: one edge, one tick
    do_load(3'd6, 16'd1, 8'd255);
    run_i = 1'b1;
    ext_clk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(!tgl_o && evt_cnt_o == 8'd255 && !flag_o, "R8 first edge",
        {tgl_o, evt_cnt_o, flag_o}, {1'b0, 8'd255, 1'b0});
    ext_clk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(tgl_o && evt_cnt_o == 8'd0 && flag_o, "R8 second edge",
        {tgl_o, evt_cnt_o, flag_o}, {1'b1, 8'd0, 1'b1});
    run_i = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule